// File: doc/BRIEF.md
# Supply Voltage Sampling Controller

This block schedules the measurements taken by an external supply-voltage comparator. Software reaches it through one 8-bit control/status register. The comparator reports a 4-bit detection level. The controller opens a measurement window of `WIN_TICKS` timebase ticks, powers the comparator through `cmp_on` while the window is open, and latches the comparator level on the final tick of the window. The latched level stays readable until the next window closes.

There are two ways to run it. In the back-to-back mode, windows follow each other with no gap. In the interval mode, one window opens every `PERIOD_TICKS` ticks; with the default 1024 Hz tick this is a 7.8 ms window every 4 s. Right after reset, hardware runs one window by itself so that the result field gets its first value. A sleep request clears both mode enables. The sleep acknowledge, which lets the oscillator stop, is held back until any open window has closed.

The controller is a five-state machine:
- `ST_BOOT` is the first sample after reset.
- `ST_IDLE` is standby.
- `ST_SAMPLE` is an open window.
- `ST_DRAIN` is a window that is finishing while sleep is pending.
- `ST_ASLEEP` is the acknowledged sleep state.

Transitions:
- BOOT→IDLE when the window closes with the back-to-back mode off.
- BOOT→SAMPLE when the window closes with the back-to-back mode on.
- BOOT→DRAIN, or SAMPLE→DRAIN, on a sleep request in mid-window.
- BOOT→ASLEEP, or SAMPLE→ASLEEP, when a sleep request arrives on the closing tick.
- IDLE→SAMPLE when the back-to-back mode is on, or when an interval is due.
- IDLE→ASLEEP on a sleep request.
- SAMPLE→SAMPLE when the window closes with the back-to-back mode still on.
- SAMPLE→IDLE when the window closes with that mode off.
- DRAIN→ASLEEP when the window closes.
- ASLEEP→IDLE when the sleep request is released.

Top module: `vsamp_ctrl`

## Requirements
- R1: While reset is held, the sleep acknowledge is 0, both mode enables are 0, and the block is in its first-sample state, so read bit 4 is 1.
- R2: After reset is released, one window of `WIN_TICKS` ticks runs with no software action. It loads the comparator level into the result, and then the block goes idle.
- R3: Read layout: bits 3..0 hold the result, bit 4 is busy (1 while a window is open), bit 5 is the interval-mode enable, and bits 7..6 read 0. Write layout: bit 4 sets the back-to-back enable and bit 5 sets the interval enable. Written values in bits 7..6 and 3..0 have no effect.
- R4: Each window spans exactly `WIN_TICKS` ticks. The level is captured on the last of those ticks as an unsigned binary value 0..15, and it is held until the next window closes.
- R5: With the back-to-back enable at 1, a new window opens on the same clock edge that closes the previous one, so busy never drops.
- R6: Clearing the back-to-back enable while a window is open lets that window finish and latch its level. After that the block is idle and opens no further window.
- R7: With the interval enable set from idle, the first window opens on the `PERIOD_TICKS`-th tick after the enable is taken. Later windows open `PERIOD_TICKS` ticks apart. Read bit 4 is 0 between windows.
- R8: With both enables at 1, the back-to-back mode takes priority: a window opens on the clock edge after the enable is taken, without waiting for an interval.
- R9: A sleep request while idle raises `sleep_ack` on the next clock edge. While `sleep_req` is high, both enables read 0 and writes to them have no effect.
- R10: A sleep request during a window holds `sleep_ack` low until the window closes and latches its level. `sleep_ack` rises on that same closing edge, and both enables read 0 from the edge after the request.
- R11: Releasing `sleep_req` while asleep drops `sleep_ack` on the next edge and returns the block to idle, with no window running.
- R12: `cmp_on` is 1 exactly while a window is open; it never overlaps `sleep_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register readback |
| lvl_in | input | 4 | Comparator detection level |
| sleep_req | input | 1 | Request to enter sleep (level) |
| cmp_on | output | 1 | Comparator enable, high during a window |
| sleep_ack | output | 1 | Sleep acknowledge: oscillator may stop |

## Verification
Back-to-back runs use levels that differ from one window to the next, so an edge that latches at the wrong moment shows as a result mismatch. Counting ticks per window separates correct window length from an off-by-one counter. Interval runs measure the tick distance from enable to the first window and between windows, which exposes a wrong reload or a wrong start phase. Sleep is requested both in idle and at random points inside windows: an early acknowledge, a lost level, or mode bits that survive sleep each show up as a distinct mismatch. Writes that carry stray bits show whether the result field can be written.

// File: rtl/vsamp_pkg.sv
package vsamp_pkg;

    localparam int REG_W    = 8;
    localparam int LVL_W    = 4;
    localparam int BIT_CONT = 4;   // write: back-to-back enable, read: busy
    localparam int BIT_PER  = 5;   // interval enable (read and write)

    typedef enum logic [2:0] {
        ST_BOOT   = 3'd0,
        ST_IDLE   = 3'd1,
        ST_SAMPLE = 3'd2,
        ST_DRAIN  = 3'd3,
        ST_ASLEEP = 3'd4
    } vs_state_e;

endpackage

// File: rtl/vsamp_tick_cnt.sv
// Counts timebase ticks while enabled; pulses 'last' on the tick that
// completes LIMIT ticks and wraps to zero on it.
module vsamp_tick_cnt #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic tick,
    output logic last
);

    generate
        if (LIMIT < 2) begin : g_single
            logic unused_pins;
            assign unused_pins = clk ^ rst_n;
            assign last = en & tick & ~clr;
        end else begin : g_count
            localparam int CW = $clog2(LIMIT);
            localparam logic [CW-1:0] END_VAL = CW'(LIMIT - 1);

            logic [CW-1:0] cnt;
            logic          at_end;

            assign at_end = (cnt == END_VAL);
            assign last   = en & tick & at_end & ~clr;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (clr) begin
                    cnt <= '0;
                end else if (en && tick) begin
                    cnt <= at_end ? '0 : cnt + CW'(1);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/vsamp_mode_reg.sv
// Mode enables and the latched detection level.
module vsamp_mode_reg
    import vsamp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             sleep_req,
    input  logic             win_done,
    input  logic [LVL_W-1:0] lvl_in,
    output logic             cont_en,
    output logic             per_en,
    output logic [LVL_W-1:0] result
);

    // Write bits other than the two enables carry no state.
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[REG_W-1:BIT_PER+1], wr_data[LVL_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cont_en <= 1'b0;
            per_en  <= 1'b0;
        end else if (sleep_req) begin
            cont_en <= 1'b0;
            per_en  <= 1'b0;
        end else if (wr_en) begin
            cont_en <= wr_data[BIT_CONT];
            per_en  <= wr_data[BIT_PER];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (win_done) begin
            result <= lvl_in;
        end
    end

endmodule

// File: rtl/vsamp_fsm.sv
// Window sequencing and sleep handshake.
module vsamp_fsm
    import vsamp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic cont_en,
    input  logic per_hit,
    input  logic win_done,
    output logic busy,
    output logic sleep_ack
);

    vs_state_e state, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BOOT;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BOOT, ST_SAMPLE: begin
                if (win_done) begin
                    if (sleep_req)    state_nx = ST_ASLEEP;
                    else if (cont_en) state_nx = ST_SAMPLE;
                    else              state_nx = ST_IDLE;
                end else if (sleep_req) begin
                    state_nx = ST_DRAIN;
                end
            end
            ST_IDLE: begin
                if (sleep_req)             state_nx = ST_ASLEEP;
                else if (cont_en || per_hit) state_nx = ST_SAMPLE;
            end
            ST_DRAIN: begin
                if (win_done) state_nx = ST_ASLEEP;
            end
            ST_ASLEEP: begin
                if (!sleep_req) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        sleep_ack = 1'b0;
        unique case (state)
            ST_BOOT, ST_SAMPLE, ST_DRAIN: busy = 1'b1;
            ST_ASLEEP:                    sleep_ack = 1'b1;
            ST_IDLE:                      ;
            default:                      ;
        endcase
    end

endmodule

// File: rtl/vsamp_ctrl.sv
module vsamp_ctrl
    import vsamp_pkg::*;
#(
    parameter int WIN_TICKS    = 8,
    parameter int PERIOD_TICKS = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [LVL_W-1:0] lvl_in,
    input  logic             sleep_req,
    output logic             cmp_on,
    output logic             sleep_ack
);

    localparam int PAD_W = REG_W - BIT_PER - 1;

    logic             busy;
    logic             win_done;
    logic             per_hit;
    logic             cont_en;
    logic             per_en;
    logic [LVL_W-1:0] result;

    vsamp_tick_cnt #(.LIMIT(WIN_TICKS)) u_win (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (~busy),
        .en   (busy),
        .tick (tick),
        .last (win_done)
    );

    vsamp_tick_cnt #(.LIMIT(PERIOD_TICKS)) u_per (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (~per_en),
        .en   (per_en),
        .tick (tick),
        .last (per_hit)
    );

    vsamp_mode_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sleep_req(sleep_req),
        .win_done (win_done),
        .lvl_in   (lvl_in),
        .cont_en  (cont_en),
        .per_en   (per_en),
        .result   (result)
    );

    vsamp_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_req(sleep_req),
        .cont_en  (cont_en),
        .per_hit  (per_hit),
        .win_done (win_done),
        .busy     (busy),
        .sleep_ack(sleep_ack)
    );

    assign cmp_on  = busy;
    assign rd_data = {{PAD_W{1'b0}}, per_en, busy, result};

endmodule

// File: rtl/vsamp_chk.sv
module vsamp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [7:0] rd_data,
    input logic [3:0] lvl_in,
    input logic       sleep_req,
    input logic       cmp_on,
    input logic       sleep_ack
);

    // R12: comparator power and sleep acknowledge are exclusive
    a_r12_on_ack_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmp_on, sleep_ack}));

    // R3: upper read bits are zero and bit 4 mirrors the open window
    a_r3_read_layout: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7:6] == 2'b00) && (rd_data[4] == cmp_on));

    // R4: the result only changes as a window closes on a tick, taking the level
    a_r4_result_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data[3:0]) |-> ($past(cmp_on) && $past(tick) && rd_data[3:0] == $past(lvl_in)));

    // R4: a window ends only on a tick
    a_r4_close_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmp_on) |-> $past(tick));

    // R9: idle sleep request acknowledged on the next edge
    a_r9_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !cmp_on && !sleep_ack) |=> sleep_ack);

    // R9 / R10: a pending sleep clears the interval enable
    a_r10_modes_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> !rd_data[5]);

    // R10: acknowledge only rises in response to a request
    a_r10_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_ack) |-> $past(sleep_req));

    // R11: release of the request drops the acknowledge
    a_r11_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_ack && !sleep_req) |=> (!sleep_ack && !cmp_on));

endmodule

bind vsamp_ctrl vsamp_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .rd_data  (rd_data),
    .lvl_in   (lvl_in),
    .sleep_req(sleep_req),
    .cmp_on   (cmp_on),
    .sleep_ack(sleep_ack)
);

// File: tb/sim_vsamp_ctrl.sv
module sim_vsamp_ctrl;

    localparam int WIN   = 4;
    localparam int PER   = 24;
    localparam int TDIV  = 4;
    localparam int SEED  = 20931;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] lvl_in = 4'h0;
    logic       sleep_req = 1'b0;
    logic [7:0] rd_data;
    logic       cmp_on;
    logic       sleep_ack;

    int checks = 0;
    int errors = 0;
    bit ended = 1'b0;

    vsamp_ctrl #(.WIN_TICKS(WIN), .PERIOD_TICKS(PER)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .lvl_in   (lvl_in),
        .sleep_req(sleep_req),
        .cmp_on   (cmp_on),
        .sleep_ack(sleep_ack)
    );

    always #4 clk = ~clk;   // 125 MHz

    initial begin
        forever begin
            repeat (TDIV - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    function automatic logic [7:0] exp_rd(bit per, bit busy, logic [3:0] res);
        return {2'b00, per, busy, res};
    endfunction

    function automatic logic [3:0] fresh_lvl(logic [3:0] old);
        return old + 4'(1 + ($urandom % 15));
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    // Sits one time unit after a rising edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    // Runs until the result changes or a window closes; counts ticks inside windows.
    task automatic measure(output int nt);
        logic [3:0] old;
        bit bp;
        bit done;
        old = rd_data[3:0];
        bp = cmp_on;
        nt = 0;
        done = 1'b0;
        while (!done) begin
            step();
            if (bp && tick) nt++;
            if (rd_data[3:0] != old || (bp && !cmp_on)) done = 1'b1;
            bp = cmp_on;
        end
    endtask

    // Counts ticks until a window opens (tick at the opening edge included).
    task automatic wait_rise(output int nt);
        nt = 0;
        do begin
            step();
            if (tick) nt++;
        end while (!cmp_on);
    endtask

    initial begin
        int nt;
        logic [3:0] cur;
        logic [3:0] expv;
        bit bad;
        void'($urandom(SEED));

        // R1: reset state
        cur = 4'($urandom);
        lvl_in = cur;
        repeat (3) step();
        chk("R1 mode bit5", int'(rd_data[5]), 0);
        chk("R1 busy bit4", int'(rd_data[4]), 1);
        chk("R1 sleep_ack", int'(sleep_ack), 0);

        // R2: automatic first sample
        rst_n = 1'b1;
        measure(nt);
        chk("R2 window ticks", nt, WIN);
        chk("R2 readback", int'(rd_data), int'(exp_rd(0, 0, cur)));
        chk("R12 cmp_on idle", int'(cmp_on), 0);

        // R3: stray write bits ignored
        wr(8'hCF);
        step();
        chk("R3 stray bits", int'(rd_data), int'(exp_rd(0, 0, cur)));

        // R4 / R5: back-to-back windows with fresh levels
        lvl_in = fresh_lvl(cur);
        wr(8'h10);
        for (int i = 0; i < 5; i++) begin
            expv = lvl_in;
            measure(nt);
            chk("R4 window ticks", nt, WIN);
            chk("R4 latched level", int'(rd_data[3:0]), int'(expv));
            chk("R5 busy kept", int'(cmp_on), 1);
            lvl_in = fresh_lvl(expv);
        end

        // R6: clear back-to-back mid-window
        wr(8'h00);
        chk("R6 still busy", int'(cmp_on), 1);
        expv = lvl_in;
        measure(nt);
        chk("R6 level latched", int'(rd_data[3:0]), int'(expv));
        chk("R6 ready", int'(cmp_on), 0);
        bad = 1'b0;
        repeat (3 * WIN * TDIV) begin
            step();
            if (cmp_on) bad = 1'b1;
        end
        chk("R6 no further window", int'(bad), 0);
        cur = expv;

        // R7: interval mode
        lvl_in = fresh_lvl(cur);
        wr(8'h20);
        wait_rise(nt);
        chk("R7 first start ticks", nt, PER);
        chk("R7 readback in window", int'(rd_data), int'(exp_rd(1, 1, cur)));
        for (int i = 0; i < 2; i++) begin
            expv = lvl_in;
            measure(nt);
            chk("R7 latched level", int'(rd_data[3:0]), int'(expv));
            chk("R7 readback between", int'(rd_data), int'(exp_rd(1, 0, expv)));
            lvl_in = fresh_lvl(expv);
            wait_rise(nt);
            chk("R7 gap ticks", nt, PER - WIN);
        end
        wr(8'h00);
        measure(nt);
        step();
        cur = rd_data[3:0];

        // R8: both enables, back-to-back wins
        lvl_in = fresh_lvl(cur);
        wr(8'h30);
        chk("R8 not yet", int'(cmp_on), 0);
        step();
        chk("R8 started", int'(cmp_on), 1);
        chk("R8 bit5", int'(rd_data[5]), 1);
        for (int i = 0; i < 2; i++) begin
            expv = lvl_in;
            measure(nt);
            chk("R8 back to back", int'(cmp_on), 1);
            lvl_in = fresh_lvl(expv);
        end

        // R10: sleep during a window
        repeat ($urandom % 6) step();
        chk("R10 busy before sleep", int'(cmp_on), 1);
        expv = lvl_in;
        sleep_req = 1'b1;
        step();
        chk("R10 bit5 cleared", int'(rd_data[5]), 0);
        bad = 1'b0;
        while (cmp_on) begin
            if (sleep_ack) bad = 1'b1;
            step();
        end
        chk("R10 ack withheld", int'(bad), 0);
        chk("R10 ack at close", int'(sleep_ack), 1);
        chk("R10 level latched", int'(rd_data[3:0]), int'(expv));

        // R9: writes ignored while asleep
        wr(8'h30);
        step();
        chk("R9 enables held", int'(rd_data[5:4]), 0);
        chk("R9 ack held", int'(sleep_ack), 1);

        // R11: wake
        sleep_req = 1'b0;
        step();
        chk("R11 ack dropped", int'(sleep_ack), 0);
        step();
        chk("R11 idle after wake", int'(cmp_on), 0);

        // R9: sleep from idle
        sleep_req = 1'b1;
        step();
        chk("R9 idle ack", int'(sleep_ack), 1);
        sleep_req = 1'b0;
        step();

        // R10 / R12: random mode, level and sleep phase
        for (int i = 0; i < 8; i++) begin
            int lat;
            lvl_in = 4'($urandom);
            wr(($urandom % 2) ? 8'h10 : 8'h20);
            repeat ($urandom % 60) step();
            sleep_req = 1'b1;
            lat = 0;
            bad = 1'b0;
            do begin
                step();
                lat++;
                if (sleep_ack && cmp_on) bad = 1'b1;
            end while (!sleep_ack && lat < 200);
            chk("R12 exclusive", int'(bad), 0);
            chk("R10 ack latency bounded", int'(lat <= WIN * TDIV + 2), 1);
            chk("R10 enables cleared", int'(rd_data[5:4]), 0);
            sleep_req = 1'b0;
            step();
            step();
        end

        finish_run();
    end

endmodule